// File: doc/BRIEF.md
# Variable Block Carry-Skip Adder

This block adds two 32-bit operands and a carry-in, giving a 32-bit sum and a carry-out. The operand bits are divided into carry-skip groups whose widths are not all the same. The groups at the two ends are narrow and the groups in the middle are wide. Inside a group, each bit cell computes a propagate term (a XOR b) and a generate term (a AND b). A two-way selector then picks the next carry: the incoming carry when propagate is set, and the generate term otherwise. Each group also ANDs its propagate terms. When every bit of the group propagates, the carry entering the group passes straight to the group's output.

The group widths are one parameter list, least significant group first. The default list keeps the carry path that starts at bit 0 short: a carry generated there ripples only through the narrow groups at the ends and skips the wide groups in the middle. Setting every entry to the same value gives a uniform carry-skip layout from the same code. The adder result is captured in an output register, so the sum and carry appear one clock after the operands are presented.

Top module: `vbsk_adder`

## Requirements
- R1: One clock after inputs are sampled, {cout_o, sum_o} equals the 33-bit arithmetic value op_a + op_b + carry_in for any operand pair.
- R2: carry_in adds exactly one to the result: all-ones plus zero with carry_in = 1 gives sum 0 and cout 1, while with carry_in = 0 it gives all ones and cout 0.
- R3: When every bit of a group has op_a and op_b different, the carry leaving that group equals the carry entering it.
- R4: The carry entering group k equals the arithmetic carry out of all bits below that group's lowest bit, and the carry entering group 0 is carry_in.
- R5: The default group widths, least significant first, are 1,3,4,5,6,5,4,3,1; the widths must add up to WIDTH, and a list that does not is rejected at elaboration.
- R6: A carry generated at bit 0 that has to travel through every higher bit (op_a = 1, op_b = all ones) gives sum 0 and cout 1.
- R7: rst_n is active-low and asynchronous; while it is low, sum_o and cout_o read 0 whatever the operands are.
- R8: With op_b the bitwise complement of op_a, so every group propagates, the sum is all ones with cout 0 when carry_in = 0, and zero with cout 1 when carry_in = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the result register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum_o | output | 32 | Registered sum |
| cout_o | output | 1 | Registered carry out of the top bit |

## Verification
Three checks run on every cycle. The registered result must match the previous cycle's arithmetic sum. Each group's incoming carry must equal the arithmetic carry out of the bits below it. Any group whose bits all propagate must pass its carry straight through. The directed scenarios cover the rest, because only chosen operands reach those cases: the longest carry path from bit 0, full propagation with both carry-in values, carries that land exactly on each group boundary, reset holding the outputs at zero, and a pass over pseudo-random operands.

// File: rtl/vbsk_pkg.sv
package vbsk_pkg;

    // Per-bit carry terms of one adder position.
    typedef struct packed {
        logic prop;
        logic gen;
    } pg_t;

endpackage

// File: rtl/vbsk_bit_cell.sv
module vbsk_bit_cell
    import vbsk_pkg::*;
(
    input  logic a_i,
    input  logic b_i,
    input  logic c_i,
    output logic s_o,
    output logic c_o
);

    pg_t pg;

    always_comb begin
        pg.prop = a_i ^ b_i;
        pg.gen  = a_i & b_i;
        s_o     = pg.prop ^ c_i;
        // selector in the carry path: pass the incoming carry or take the generate term
        c_o     = pg.prop ? c_i : pg.gen;
    end

endmodule

// File: rtl/vbsk_group.sv
module vbsk_group #(
    parameter int unsigned W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] s_o,
    output logic         cout_o
);

    logic [W:0]   rip;
    logic [W-1:0] bit_p;
    logic         all_p;

    assign rip[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_bit
        vbsk_bit_cell u_cell (
            .a_i (a_i[i]),
            .b_i (b_i[i]),
            .c_i (rip[i]),
            .s_o (s_o[i]),
            .c_o (rip[i+1])
        );
        assign bit_p[i] = a_i[i] ^ b_i[i];
    end

    assign all_p = &bit_p;

    // bypass path OR rippled carry; both give the same logical value
    assign cout_o = (all_p & cin_i) | rip[W];

endmodule

// File: rtl/vbsk_adder.sv
module vbsk_adder #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUPS = 9,
    parameter int unsigned GSIZE [GROUPS] = '{1, 3, 4, 5, 6, 5, 4, 3, 1}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum_o,
    output logic             cout_o
);

    function automatic int unsigned grp_base(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += GSIZE[i];
        return acc;
    endfunction

    localparam int unsigned TOTAL = grp_base(GROUPS);

    // R5: the group widths must cover the operand exactly
    if (TOTAL != WIDTH) begin : g_size_bad
        $error("group widths add to %0d, operand width is %0d", TOTAL, WIDTH);
    end

    typedef struct packed {
        logic [WIDTH-1:0] sum;
        logic             cout;
    } res_t;

    logic [GROUPS-1:0] grp_cin;
    logic [GROUPS-1:0] grp_cout;
    logic [WIDTH-1:0]  sum_w;
    res_t              res_d, res_q;

    assign grp_cin[0] = carry_in;

    for (genvar k = 0; k < GROUPS; k++) begin : g_grp
        localparam int unsigned BASE = grp_base(k);
        localparam int unsigned SZ   = GSIZE[k];

        vbsk_group #(.W(SZ)) u_grp (
            .a_i    (op_a[BASE +: SZ]),
            .b_i    (op_b[BASE +: SZ]),
            .cin_i  (grp_cin[k]),
            .s_o    (sum_w[BASE +: SZ]),
            .cout_o (grp_cout[k])
        );

        if (k > 0) begin : g_link
            assign grp_cin[k] = grp_cout[k-1];
        end
    end

    always_comb begin
        res_d      = res_q;
        res_d.sum  = sum_w;
        res_d.cout = grp_cout[GROUPS-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign sum_o  = res_q.sum;
    assign cout_o = res_q.cout;

endmodule

// File: rtl/vbsk_adder_chk.sv
module vbsk_adder_chk #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned GROUPS = 9,
    parameter int unsigned GSIZE [GROUPS] = '{1, 3, 4, 5, 6, 5, 4, 3, 1}
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WIDTH-1:0]  op_a,
    input logic [WIDTH-1:0]  op_b,
    input logic              carry_in,
    input logic [WIDTH-1:0]  sum_o,
    input logic              cout_o,
    input logic [GROUPS-1:0] grp_cin,
    input logic [GROUPS-1:0] grp_cout
);

    function automatic int unsigned base_of(input int unsigned k);
        int unsigned acc = 0;
        for (int unsigned i = 0; i < k; i++) acc += GSIZE[i];
        return acc;
    endfunction

    logic [WIDTH:0] full_ref;
    assign full_ref = {1'b0, op_a} + {1'b0, op_b} + {{WIDTH{1'b0}}, carry_in};

    // R1
    result_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ({cout_o, sum_o} == $past(full_ref)));

    for (genvar k = 0; k < GROUPS; k++) begin : g_chk
        localparam int unsigned BASE = base_of(k);
        localparam int unsigned SZ   = GSIZE[k];
        logic [WIDTH-1:0] low_mask;
        logic [WIDTH:0]   low_sum;
        logic [SZ-1:0]    grp_p;

        assign low_mask = (BASE == 0) ? '0 : ({WIDTH{1'b1}} >> (WIDTH - BASE));
        assign low_sum  = {1'b0, op_a & low_mask} + {1'b0, op_b & low_mask}
                        + {{WIDTH{1'b0}}, carry_in};
        assign grp_p    = op_a[BASE +: SZ] ^ op_b[BASE +: SZ];

        // R4
        group_carry_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            grp_cin[k] == low_sum[BASE]);

        // R3
        group_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (&grp_p) |-> (grp_cout[k] == grp_cin[k]));
    end

    // R7
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_o == '0 && cout_o == 1'b0));

endmodule

bind vbsk_adder vbsk_adder_chk #(
    .WIDTH  (WIDTH),
    .GROUPS (GROUPS),
    .GSIZE  (GSIZE)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_a     (op_a),
    .op_b     (op_b),
    .carry_in (carry_in),
    .sum_o    (sum_o),
    .cout_o   (cout_o),
    .grp_cin  (grp_cin),
    .grp_cout (grp_cout)
);

// File: tb/vbsk_adder_tb.sv
`timescale 1ns/1ps
module vbsk_adder_tb;

    localparam int unsigned W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic         carry_in = 1'b0;
    logic [W-1:0] sum_o;
    logic         cout_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    vbsk_adder u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_a     (op_a),
        .op_b     (op_b),
        .carry_in (carry_in),
        .sum_o    (sum_o),
        .cout_o   (cout_o)
    );

    task automatic check(input string req, input logic [W:0] got, input logic [W:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive at a falling edge, the rising edge registers, sample at the next falling edge
    task automatic apply(input string req, input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic ci);
        logic [W:0] exp;
        op_a = a; op_b = b; carry_in = ci;
        exp = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
        @(negedge clk);
        check(req, {cout_o, sum_o}, exp);
    endtask

    task automatic t_reset();
        // R7: outputs held at zero while reset is low, whatever the operands
        op_a = 32'hFFFF_FFFF; op_b = 32'h0000_0001; carry_in = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7 reset hold", {cout_o, sum_o}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 first result after reset", {cout_o, sum_o}, {1'b1, 32'h0000_0001});
    endtask

    task automatic t_carry_in();
        // R2
        apply("R2 ones cin1", 32'hFFFF_FFFF, 32'h0, 1'b1);
        apply("R2 ones cin0", 32'hFFFF_FFFF, 32'h0, 1'b0);
        apply("R2 ones plus one", 32'hFFFF_FFFF, 32'h1, 1'b0);
        apply("R2 zero cin1", 32'h0, 32'h0, 1'b1);
    endtask

    task automatic t_long_chain();
        // R6
        apply("R6 bit0 to top", 32'h0000_0001, 32'hFFFF_FFFF, 1'b0);
        apply("R6 bit0 to top cin1", 32'h0000_0001, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_full_propagate();
        // R8 and R3: every group propagates
        apply("R8 alt cin0", 32'hAAAA_AAAA, 32'h5555_5555, 1'b0);
        apply("R8 alt cin1", 32'hAAAA_AAAA, 32'h5555_5555, 1'b1);
        apply("R8 mixed cin0", 32'h1234_5678, ~32'h1234_5678, 1'b0);
        apply("R8 mixed cin1", 32'h1234_5678, ~32'h1234_5678, 1'b1);
    endtask

    task automatic t_boundaries();
        // R5 and R4: carry that lands exactly on each default group boundary
        int unsigned sizes [9] = '{1, 3, 4, 5, 6, 5, 4, 3, 1};
        int unsigned base = 0;
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] lowones;
            base += sizes[k];
            lowones = (32'h1 << base) - 32'h1;
            apply("R5 boundary carry", lowones, 32'h1, 1'b0);
            apply("R4 boundary carry cin", lowones, 32'h0, 1'b1);
        end
        apply("R4 alternating same", 32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b1);
    endtask

    task automatic t_random();
        // R1
        for (int i = 0; i < 300; i++) begin
            apply("R1 random", $urandom, $urandom, 1'($urandom));
        end
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_carry_in();
        t_long_chain();
        t_full_propagate();
        t_boundaries();
        t_random();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule